// File: doc/BRIEF.md
# Automatic Gain Control Loop with PWM Gain Output

This block measures the strength of a complex baseband signal and produces a pulse-width-modulated gain control signal for an external amplifier. On every sample clock it squares the signed in-phase and quadrature samples and adds them, giving a 16-bit power figure. The top byte of that figure is presented as a level reading that a host can poll.

A mode input selects who owns the gain. In host-driven mode, the 8-bit value on the gain/reference input goes straight to the PWM generator. In self-regulating mode, that same byte is a target level. An interval timer, whose period is a power of two chosen by a 3-bit code, fires at regular points. At each firing the block compares the current level byte with the target and nudges its own gain register one step toward agreement. The PWM output is meant to be smoothed by an external low-pass filter. A polarity input flips its sense.

Top module: `agc_pwm_loop`

## Requirements
- R1: `levelOut` equals bits [15:8] of I*I+Q*Q, with I and Q read as two's complement, one clock after the samples are presented.
- R2: While reset is asserted, `levelOut` is 0x00 and `pwmOut` is 0. On release, the internal gain is 0x80 and the interval counter is zero.
- R3: In host-driven mode (`masterMode`=0) with `polarityPos`=1, `pwmOut` is high for exactly `gainRef` clocks in every window of 256 consecutive clocks.
- R4: With `polarityPos`=0, `pwmOut` is high for 256 minus the duty value clocks in every 256-clock window.
- R5: In self-regulating mode, at each interval tick the internal gain drops by one when the level byte exceeds `gainRef`, rises by one when it is below, and holds when they are equal. The PWM then uses the internal gain as its duty.
- R6: In self-regulating mode, ticks occur every 2^(BASE_EXP+`timerSel`) clocks, counted from reset release or from leaving host-driven mode. The first tick falls on the last clock of the first period.
- R7: The internal gain saturates at 0x00 and at 0xFF and never wraps.
- R8: In host-driven mode the interval counter stays cleared and the internal gain does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| iSample | input | 8 | In-phase sample, two's complement |
| qSample | input | 8 | Quadrature sample, two's complement |
| masterMode | input | 1 | 1 = self-regulating loop, 0 = host-driven gain |
| timerSel | input | 3 | Interval code; period 2^(BASE_EXP+code) clocks |
| gainRef | input | 8 | Gain value (host-driven) or target level (self-regulating) |
| polarityPos | input | 1 | 1 = positive PWM sense, 0 = inverted |
| levelOut | output | 8 | Upper byte of the I/Q power estimate |
| pwmOut | output | 1 | PWM gain control, 256-clock period |

## Verification
The level path is driven with a table of sample pairs. The table covers zero, pure in-phase, both axes at the most negative code, both at the most positive code, and mixed signs. These separate a correct signed square from an unsigned one, and a proper upper-byte slice from an off-by-one slice. The loop is run with the level above, below and equal to the target, for a fixed number of clocks under two interval codes. The resulting gain is then frozen by switching to the longest interval and read back through the PWM duty. This gives the direction, the step size and the tick period in one measurement. Long runs against extreme targets show saturation at both rails. A host-driven run followed by a switch to the loop shows that the gain was left untouched.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Strobes from the loop controller to the datapath
  typedef struct packed {
    logic tick;
    logic incGain;
    logic decGain;
  } ctrlStrobes_t;
endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int LEVEL_W  = 8,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterMode,
  input  logic [SEL_W-1:0]   timerSel,
  input  logic [LEVEL_W-1:0] levelByte,
  input  logic [LEVEL_W-1:0] refByte,
  output ctrlStrobes_t       strb
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W);

  logic [CNT_W-1:0] timerCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             tickNow;

  assign lastCnt = (CNT_W'(1) << (BASE_EXP + int'(timerSel))) - CNT_W'(1);
  assign tickNow = masterMode && (timerCnt >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN || !masterMode) begin
      timerCnt <= '0;
    end else if (tickNow) begin
      timerCnt <= '0;
    end else begin
      timerCnt <= timerCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb.tick    = tickNow;
    strb.incGain = tickNow && (levelByte < refByte);
    strb.decGain = tickNow && (levelByte > refByte);
  end

  // R6
  tick_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |-> masterMode);
  // R5
  step_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incGain, strb.decGain}));
  // R8
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (timerCnt == '0));
endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int GAIN_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic [SAMPLE_W-1:0] qSample,
  input  logic                masterMode,
  input  logic [GAIN_W-1:0]   gainRef,
  input  logic                polarityPos,
  input  ctrlStrobes_t        strb,
  output logic [GAIN_W-1:0]   levelByte,
  output logic                pwmOut
);
  localparam int POWER_W = 2 * SAMPLE_W;
  localparam logic [GAIN_W-1:0] GAIN_INIT = GAIN_W'(1) << (GAIN_W - 1);

  logic signed [POWER_W-1:0] iSq, qSq;
  logic [POWER_W-1:0] powerNext, powerReg;
  logic [GAIN_W-1:0]  gainReg, pwmCnt, duty;
  logic               pwmRaw;

  assign iSq       = $signed(iSample) * $signed(iSample);
  assign qSq       = $signed(qSample) * $signed(qSample);
  assign powerNext = POWER_W'(iSq) + POWER_W'(qSq);
  assign levelByte = powerReg[POWER_W-1 -: GAIN_W];

  always_ff @(posedge clk) begin
    if (!rstN) powerReg <= '0;
    else       powerReg <= powerNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainReg <= GAIN_INIT;
    end else if (strb.incGain && (gainReg != '1)) begin
      gainReg <= gainReg + GAIN_W'(1);
    end else if (strb.decGain && (gainReg != '0)) begin
      gainReg <= gainReg - GAIN_W'(1);
    end
  end

  assign duty   = masterMode ? gainReg : gainRef;
  assign pwmRaw = (pwmCnt < duty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmCnt <= '0;
      pwmOut <= 1'b0;
    end else begin
      pwmCnt <= pwmCnt + GAIN_W'(1);
      pwmOut <= polarityPos ? pwmRaw : !pwmRaw;
    end
  end

  // R5
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incGain && !strb.decGain) |=> $stable(gainReg));
  // R7
  gain_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incGain && gainReg == '1) |=> (gainReg == '1));
  // R7
  gain_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decGain && gainReg == '0) |=> (gainReg == '0));
  // R3
  pwm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (duty == '0 && polarityPos) |=> !pwmOut);
endmodule

// File: rtl/agc_pwm_loop.sv
module agc_pwm_loop
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int GAIN_W   = 8,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic [SAMPLE_W-1:0] qSample,
  input  logic                masterMode,
  input  logic [SEL_W-1:0]    timerSel,
  input  logic [GAIN_W-1:0]   gainRef,
  input  logic                polarityPos,
  output logic [GAIN_W-1:0]   levelOut,
  output logic                pwmOut
);
  ctrlStrobes_t strb;

  agc_ctrl #(
    .LEVEL_W(GAIN_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .timerSel(timerSel),
    .levelByte(levelOut), .refByte(gainRef), .strb(strb)
  );

  agc_datapath #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .iSample(iSample), .qSample(qSample),
    .masterMode(masterMode), .gainRef(gainRef), .polarityPos(polarityPos),
    .strb(strb), .levelByte(levelOut), .pwmOut(pwmOut)
  );
endmodule

// File: tb/agc_pwm_loop_tb.sv
`timescale 1ns/1ps
module agc_pwm_loop_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] iSample = '0, qSample = '0;
  logic       masterMode = 1'b0;
  logic [2:0] timerSel = '0;
  logic [7:0] gainRef = '0;
  logic       polarityPos = 1'b1;
  logic [7:0] levelOut;
  logic       pwmOut;
  int testCnt = 0, failCnt = 0;

  always #5 clk = ~clk;

  agc_pwm_loop #(.BASE_EXP(2)) dut_i (
    .clk(clk), .rstN(rstN), .iSample(iSample), .qSample(qSample),
    .masterMode(masterMode), .timerSel(timerSel), .gainRef(gainRef),
    .polarityPos(polarityPos), .levelOut(levelOut), .pwmOut(pwmOut)
  );

  // {I, Q, expected level byte}
  localparam logic [23:0] LEVEL_VEC [8] = '{
    {8'd0,    8'd0,    8'h00},
    {8'd100,  8'd0,    8'h27},
    {8'h80,   8'h80,   8'h80},
    {8'd127,  8'd127,  8'h7E},
    {8'hCE,   8'd30,   8'h0D},
    {8'd16,   8'd0,    8'h01},
    {8'd15,   8'd15,   8'h01},
    {8'hFF,   8'd0,    8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; masterMode = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pwmHigh(output int hi);
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  // Run the loop for a fixed number of clocks after reset, freeze, read gain
  task automatic runLoop(input string req, input logic [2:0] code, input int cycles,
                         input logic [7:0] iv, input logic [7:0] qv,
                         input logic [7:0] refv, input int expGain);
    int hi;
    iSample = iv; qSample = qv; gainRef = refv; timerSel = code; polarityPos = 1'b1;
    doReset(1'b1);
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    timerSel = 3'd7;
    pwmHigh(hi);
    check(req, hi, expGain);
  endtask

  initial begin
    #2_000_000;
    failCnt++; testCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int hi;
    // R2: reset state
    iSample = 8'd100;
    repeat (3) @(negedge clk);
    check("R2 level in reset", levelOut, 0);
    check("R2 pwm in reset", pwmOut, 0);
    rstN = 1'b1;

    // R1: level table
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      iSample = LEVEL_VEC[n][23:16]; qSample = LEVEL_VEC[n][15:8];
      @(negedge clk);
      check("R1 level", levelOut, LEVEL_VEC[n][7:0]);
    end

    // R3 / R4: host-driven PWM duty and polarity
    masterMode = 1'b0;
    gainRef = 8'h40; polarityPos = 1'b1; @(negedge clk); pwmHigh(hi); check("R3 duty 0x40", hi, 64);
    gainRef = 8'h00; @(negedge clk); pwmHigh(hi); check("R3 duty 0x00", hi, 0);
    gainRef = 8'hFF; @(negedge clk); pwmHigh(hi); check("R3 duty 0xFF", hi, 255);
    polarityPos = 1'b0; @(negedge clk); pwmHigh(hi); check("R4 inverted 0xFF", hi, 1);
    gainRef = 8'h40; @(negedge clk); pwmHigh(hi); check("R4 inverted 0x40", hi, 192);

    // R2 / R5 / R6: loop direction and tick period (level 0x27, 0x00, 0x10)
    runLoop("R5 R6 down code0", 3'd0, 40, 8'd100, 8'd0, 8'h10, 8'h76);
    runLoop("R5 R6 up code0",   3'd0, 40, 8'd10,  8'd10, 8'h40, 8'h8A);
    runLoop("R5 equal holds",   3'd0, 40, 8'd64,  8'd0, 8'h10, 8'h80);
    runLoop("R6 down code1",    3'd1, 40, 8'd100, 8'd0, 8'h10, 8'h7B);
    runLoop("R2 gain init",     3'd0, 3,  8'd100, 8'd0, 8'h10, 8'h80);

    // R7: saturation at both rails
    runLoop("R7 floor", 3'd0, 1200, 8'd100, 8'd0, 8'h10, 0);
    runLoop("R7 ceiling", 3'd0, 1200, 8'd0, 8'd0, 8'hFF, 255);

    // R8: host-driven mode leaves gain and timer untouched
    iSample = 8'd100; qSample = 8'd0; gainRef = 8'h10; timerSel = 3'd0; polarityPos = 1'b1;
    doReset(1'b0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    timerSel = 3'd7; masterMode = 1'b1;
    pwmHigh(hi);
    check("R8 gain kept", hi, 8'h80);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule